// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Resolver

This block sits beside a group of up to eight local interrupt controllers and turns an interprocessor interrupt command into a set of target processors. It then gives each selected target a one-cycle delivery strobe of the kind the command asks for. Software, or a neighbouring register block, loads a two-word command. The upper word carries the destination. Loading the lower word launches the send. A small per-target table holds each processor's physical ID, logical ID and logical addressing format, and that table decides which processors match a given destination.

Targets can be named in three ways: by physical ID, by flat logical addressing (any shared bit), or by cluster logical addressing (same cluster nibble and a shared member bit). Four shorthands override the destination: none, the sender only, everyone, and everyone but the sender. Lowest-priority delivery goes to the lowest-numbered selected target. An INIT command encoded as level-deassert delivers nothing. Instead it makes every selected target copy its physical ID into its arbitration ID.

Top module: `ipi_dest_resolver`

## Requirements
- R1: A write with `cmd_wr_hi`=1 only stores the destination, which is bits [31:24] of that word, and produces no strobe. A write with `cmd_wr_hi`=0 stores the low word and starts a send. The low-word fields are: vector [7:0], delivery mode [10:8], logical-destination flag [11], level [14], trigger [15] and shorthand [19:18].
- R2: A low-word write that is sampled on clock edge k updates `tgt_mask`, `vec_out`, `trig_out` and the strobes on edge k+1. The strobes are high for that one cycle only. Back-to-back sends each produce their own one-cycle strobes.
- R3: The shorthand code selects the targets. Code 0 uses the destination field. Code 1 selects only target `sender_idx`. Code 2 selects all targets. Code 3 selects all targets except `sender_idx`.
- R4: With shorthand 0 and the logical flag at 0, destination 0xFF selects every target. Any other destination selects each target whose physical ID equals it. If no target has that ID, no target is selected.
- R5: With shorthand 0 and the logical flag at 1, a target whose format is 0xF is selected when the destination AND its logical ID is nonzero.
- R6: With shorthand 0 and the logical flag at 1, a target whose format is 0x0 is selected when destination[7:4] equals logical ID[7:4] and destination[3:0] AND logical ID[3:0] is nonzero. A target with any other format is never selected by logical addressing.
- R7: Delivery mode 0 (fixed) pulses `fixed_stb` for every selected target. `vec_out` carries the vector and `trig_out` carries the trigger bit.
- R8: Delivery mode 1 (lowest priority) pulses `fixed_stb` only for the lowest-numbered selected target. If no target is selected, no strobe is raised.
- R9: Delivery mode 2 pulses `smi_stb` and mode 4 pulses `nmi_stb` for every selected target. Mode 5 pulses `init_stb` for every selected target, unless the level-deassert encoding of R10 applies.
- R10: Mode 5 with level 0 and trigger 1 raises no delivery strobe. It pulses `resync_stb` for the selected targets, and on that same edge each of them copies its physical ID into its arbitration ID, which is visible on `arb_id_flat` (target i at bits [8i+7:8i]).
- R11: Delivery mode 6 (startup) pulses `start_stb` for every selected target, with the start vector on `vec_out`.
- R12: Delivery modes 3 and 7 still update `tgt_mask` but raise no strobe of any kind.
- R13: After reset every output is 0, every arbitration ID is 0, and target i's table holds physical ID i, logical ID 0x00 and format 0xF. A table write with `tbl_wr_en` replaces all three table fields of target `tbl_wr_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Command word write strobe |
| cmd_wr_hi | input | 1 | 1 selects the high command word, 0 the low word (starts a send) |
| cmd_wr_data | input | 32 | Command word data |
| sender_idx | input | 3 | Index of the processor issuing the command |
| tbl_wr_en | input | 1 | Target table write strobe |
| tbl_wr_idx | input | 3 | Target table entry to write |
| tbl_phys_id | input | 8 | Physical ID to store |
| tbl_log_id | input | 8 | Logical ID to store |
| tbl_fmt | input | 4 | Logical format to store (0xF flat, 0x0 cluster) |
| tgt_mask | output | 8 | Targets resolved by the latest send |
| fixed_stb | output | 8 | Per-target fixed-vector strobe |
| nmi_stb | output | 8 | Per-target NMI strobe |
| smi_stb | output | 8 | Per-target SMI strobe |
| init_stb | output | 8 | Per-target INIT strobe |
| start_stb | output | 8 | Per-target startup strobe |
| resync_stb | output | 8 | Per-target arbitration ID resync strobe |
| vec_out | output | 8 | Vector of the latest send |
| trig_out | output | 1 | Trigger bit of the latest send |
| arb_id_flat | output | 64 | Arbitration IDs, 8 bits per target |

## Verification
The bench goes after the corners where a small slip changes the set of targets. It sends a physical destination that matches no one, which a design with a stray default would turn into a broadcast. It sends a cluster destination whose nibble matches but whose member bits do not, and it gives a target a format that is neither flat nor cluster, which a loose match would still select. It sends a lowest-priority command to an empty set, which a careless priority pick could send to target 0. It also covers the INIT level-deassert encoding, which a design that ignored the level and trigger bits would deliver as a real INIT without updating the arbitration IDs. Finally, it uses the reserved modes and back-to-back sends, which expose strobes that leak into a second cycle or appear for codes that should stay quiet.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD3  = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_RSVD7  = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } short_e;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_BCAST  = 8'hFF;

  typedef struct packed {
    logic [7:0] dest;
    short_e     sh;
    logic       trig;
    logic       lvl;
    logic       logical;
    dmode_e     mode;
    logic [7:0] vec;
  } cmd_t;

endpackage

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_hi,
  input  logic [31:0] wr_data,
  output cmd_t        cmd,
  output logic        go
);
  logic unused_bits;
  assign unused_bits = ^{wr_data[23:20], wr_data[17:16], wr_data[13:12]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= '0;
      go  <= 1'b0;
    end else begin
      go <= wr_en && !wr_hi;
      if (wr_en) begin
        if (wr_hi) begin
          cmd.dest <= wr_data[31:24];
        end else begin
          cmd.vec     <= wr_data[7:0];
          cmd.mode    <= dmode_e'(wr_data[10:8]);
          cmd.logical <= wr_data[11];
          cmd.lvl     <= wr_data[14];
          cmd.trig    <= wr_data[15];
          cmd.sh      <= short_e'(wr_data[19:18]);
        end
      end
    end
  end
endmodule

// File: rtl/ipi_target_table.sv
module ipi_target_table #(
  parameter int NPROC = 8,
  parameter int ID_W  = 8,
  parameter int FMT_W = 4,
  localparam int IDX_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [ID_W-1:0]         wr_phys,
  input  logic [ID_W-1:0]         wr_log,
  input  logic [FMT_W-1:0]        wr_fmt,
  input  logic [NPROC-1:0]        resync_mask,
  output logic [NPROC*ID_W-1:0]   phys_flat,
  output logic [NPROC*ID_W-1:0]   log_flat,
  output logic [NPROC*FMT_W-1:0]  fmt_flat,
  output logic [NPROC*ID_W-1:0]   arb_flat
);
  for (genvar i = 0; i < NPROC; i++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        phys_flat[i*ID_W +: ID_W] <= ID_W'(i);
        log_flat[i*ID_W +: ID_W]  <= '0;
        fmt_flat[i*FMT_W +: FMT_W] <= '1;
        arb_flat[i*ID_W +: ID_W]  <= '0;
      end else begin
        if (sel) begin
          phys_flat[i*ID_W +: ID_W]  <= wr_phys;
          log_flat[i*ID_W +: ID_W]   <= wr_log;
          fmt_flat[i*FMT_W +: FMT_W] <= wr_fmt;
        end
        if (resync_mask[i]) begin
          arb_flat[i*ID_W +: ID_W] <= phys_flat[i*ID_W +: ID_W];
        end
      end
    end

    // R10
    resync_copy_chk: assert property (@(posedge clk) disable iff (rst)
      $past(resync_mask[i] && !sel) |-> arb_flat[i*ID_W +: ID_W] == $past(phys_flat[i*ID_W +: ID_W]));
  end
endmodule

// File: rtl/ipi_target_match.sv
module ipi_target_match
  import ipi_pkg::*;
#(
  parameter int NPROC = 8,
  parameter int ID_W  = 8,
  parameter int FMT_W = 4,
  localparam int IDX_W = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int HALF  = ID_W / 2
) (
  input  logic [ID_W-1:0]        dest,
  input  short_e                 sh,
  input  logic                   logical,
  input  logic [IDX_W-1:0]       sender_idx,
  input  logic [NPROC*ID_W-1:0]  phys_flat,
  input  logic [NPROC*ID_W-1:0]  log_flat,
  input  logic [NPROC*FMT_W-1:0] fmt_flat,
  output logic [NPROC-1:0]       mask
);
  logic [NPROC-1:0] dest_hit;
  logic [NPROC-1:0] self_oh;

  assign self_oh = {{(NPROC-1){1'b0}}, 1'b1} << sender_idx;

  for (genvar i = 0; i < NPROC; i++) begin : g_cmp
    logic [ID_W-1:0]  pid;
    logic [ID_W-1:0]  lid;
    logic [FMT_W-1:0] fmt;
    logic phys_hit, flat_hit, clus_hit;
    assign pid = phys_flat[i*ID_W +: ID_W];
    assign lid = log_flat[i*ID_W +: ID_W];
    assign fmt = fmt_flat[i*FMT_W +: FMT_W];
    assign phys_hit = (dest == ID_W'(DEST_BCAST)) || (dest == pid);
    assign flat_hit = (fmt == FMT_W'(FMT_FLAT)) && |(dest & lid);
    assign clus_hit = (fmt == FMT_W'(FMT_CLUSTER)) &&
                      (dest[ID_W-1:HALF] == lid[ID_W-1:HALF]) &&
                      |(dest[HALF-1:0] & lid[HALF-1:0]);
    assign dest_hit[i] = logical ? (flat_hit || clus_hit) : phys_hit;
  end

  always_comb begin
    unique case (sh)
      SH_DEST:   mask = dest_hit;
      SH_SELF:   mask = self_oh;
      SH_ALL:    mask = '1;
      default:   mask = ~self_oh;
    endcase
  end
endmodule

// File: rtl/ipi_delivery.sv
module ipi_delivery
  import ipi_pkg::*;
#(
  parameter int NPROC = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  dmode_e           mode,
  input  logic             lvl,
  input  logic             trig,
  input  logic [VEC_W-1:0] vec,
  input  logic [NPROC-1:0] mask_in,
  output logic [NPROC-1:0] resync_now,
  output logic [NPROC-1:0] tgt_mask,
  output logic [NPROC-1:0] fixed_stb,
  output logic [NPROC-1:0] nmi_stb,
  output logic [NPROC-1:0] smi_stb,
  output logic [NPROC-1:0] init_stb,
  output logic [NPROC-1:0] start_stb,
  output logic [NPROC-1:0] resync_stb,
  output logic [VEC_W-1:0] vec_out,
  output logic             trig_out
);
  logic [NPROC-1:0] low_pick;
  logic [NPROC-1:0] fix_d, nmi_d, smi_d, ini_d, sta_d;
  logic [NPROC-1:0] any_stb;

  assign low_pick = mask_in & (~mask_in + NPROC'(1));

  always_comb begin
    fix_d = '0; nmi_d = '0; smi_d = '0; ini_d = '0; sta_d = '0; resync_now = '0;
    if (go) begin
      case (mode)
        DM_FIXED:  fix_d = mask_in;
        DM_LOWEST: fix_d = low_pick;
        DM_SMI:    smi_d = mask_in;
        DM_NMI:    nmi_d = mask_in;
        DM_INIT:   if (!lvl && trig) resync_now = mask_in;
                   else ini_d = mask_in;
        DM_START:  sta_d = mask_in;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_mask   <= '0;
      fixed_stb  <= '0;
      nmi_stb    <= '0;
      smi_stb    <= '0;
      init_stb   <= '0;
      start_stb  <= '0;
      resync_stb <= '0;
      vec_out    <= '0;
      trig_out   <= 1'b0;
    end else begin
      fixed_stb  <= fix_d;
      nmi_stb    <= nmi_d;
      smi_stb    <= smi_d;
      init_stb   <= ini_d;
      start_stb  <= sta_d;
      resync_stb <= resync_now;
      if (go) begin
        tgt_mask <= mask_in;
        vec_out  <= vec;
        trig_out <= trig;
      end
    end
  end

  assign any_stb = fixed_stb | nmi_stb | smi_stb | init_stb | start_stb | resync_stb;

  // R2
  stb_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
    (|any_stb) |-> $past(go));

  // R7
  stb_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (any_stb & ~tgt_mask) == '0);

  // R8
  lowest_single_chk: assert property (@(posedge clk) disable iff (rst)
    $past(go && mode == DM_LOWEST) |-> $onehot0(fixed_stb));

  // R10
  resync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(go && mode == DM_INIT && !lvl && trig) |->
      (fixed_stb | nmi_stb | smi_stb | init_stb | start_stb) == '0);

  // R12
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(go && (mode == DM_RSVD3 || mode == DM_RSVD7)) |-> any_stb == '0);
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_pkg::*;
#(
  parameter int NPROC = 8,
  parameter int ID_W  = 8,
  parameter int FMT_W = 4,
  parameter int VEC_W = 8,
  localparam int IDX_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_wr_en,
  input  logic                  cmd_wr_hi,
  input  logic [31:0]           cmd_wr_data,
  input  logic [IDX_W-1:0]      sender_idx,
  input  logic                  tbl_wr_en,
  input  logic [IDX_W-1:0]      tbl_wr_idx,
  input  logic [ID_W-1:0]       tbl_phys_id,
  input  logic [ID_W-1:0]       tbl_log_id,
  input  logic [FMT_W-1:0]      tbl_fmt,
  output logic [NPROC-1:0]      tgt_mask,
  output logic [NPROC-1:0]      fixed_stb,
  output logic [NPROC-1:0]      nmi_stb,
  output logic [NPROC-1:0]      smi_stb,
  output logic [NPROC-1:0]      init_stb,
  output logic [NPROC-1:0]      start_stb,
  output logic [NPROC-1:0]      resync_stb,
  output logic [VEC_W-1:0]      vec_out,
  output logic                  trig_out,
  output logic [NPROC*ID_W-1:0] arb_id_flat
);
  cmd_t                   cmd;
  logic                   go;
  logic [NPROC-1:0]       mask;
  logic [NPROC-1:0]       resync_now;
  logic [NPROC*ID_W-1:0]  phys_flat, log_flat;
  logic [NPROC*FMT_W-1:0] fmt_flat;

  ipi_cmd_reg u_cmd (
    .clk(clk), .rst(rst), .wr_en(cmd_wr_en), .wr_hi(cmd_wr_hi),
    .wr_data(cmd_wr_data), .cmd(cmd), .go(go)
  );

  ipi_target_table #(.NPROC(NPROC), .ID_W(ID_W), .FMT_W(FMT_W)) u_tbl (
    .clk(clk), .rst(rst), .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx),
    .wr_phys(tbl_phys_id), .wr_log(tbl_log_id), .wr_fmt(tbl_fmt),
    .resync_mask(resync_now), .phys_flat(phys_flat), .log_flat(log_flat),
    .fmt_flat(fmt_flat), .arb_flat(arb_id_flat)
  );

  ipi_target_match #(.NPROC(NPROC), .ID_W(ID_W), .FMT_W(FMT_W)) u_match (
    .dest(cmd.dest), .sh(cmd.sh), .logical(cmd.logical), .sender_idx(sender_idx),
    .phys_flat(phys_flat), .log_flat(log_flat), .fmt_flat(fmt_flat), .mask(mask)
  );

  ipi_delivery #(.NPROC(NPROC), .VEC_W(VEC_W)) u_dlv (
    .clk(clk), .rst(rst), .go(go), .mode(cmd.mode), .lvl(cmd.lvl),
    .trig(cmd.trig), .vec(cmd.vec), .mask_in(mask), .resync_now(resync_now),
    .tgt_mask(tgt_mask), .fixed_stb(fixed_stb), .nmi_stb(nmi_stb),
    .smi_stb(smi_stb), .init_stb(init_stb), .start_stb(start_stb),
    .resync_stb(resync_stb), .vec_out(vec_out), .trig_out(trig_out)
  );

  // R1
  hi_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_en && cmd_wr_hi) |=> ##1
      (fixed_stb | nmi_stb | smi_stb | init_stb | start_stb | resync_stb) == '0);

  // R3
  self_only_chk: assert property (@(posedge clk) disable iff (rst)
    $past(go && cmd.sh == SH_SELF) |->
      tgt_mask == ({{(NPROC-1){1'b0}}, 1'b1} << $past(sender_idx)));
endmodule

// File: tb/sim_ipi_dest_resolver.sv
module sim_ipi_dest_resolver;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr_en = 1'b0, cmd_wr_hi = 1'b0;
  logic [31:0] cmd_wr_data = '0;
  logic [2:0]  sender_idx = '0;
  logic        tbl_wr_en = 1'b0;
  logic [2:0]  tbl_wr_idx = '0;
  logic [7:0]  tbl_phys_id = '0, tbl_log_id = '0;
  logic [3:0]  tbl_fmt = '0;
  logic [7:0]  tgt_mask, fixed_stb, nmi_stb, smi_stb, init_stb, start_stb, resync_stb, vec_out;
  logic        trig_out;
  logic [63:0] arb_id_flat;

  ipi_dest_resolver u0 (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  int checks = 0, failures = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [7:0]  mask;
    logic [47:0] stb;
    logic [7:0]  vec;
    logic        trig;
    logic [63:0] arb;
    int          due;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [7:0] m_phys[N], m_log[N], m_arb[N];
  logic [3:0] m_fmt[N];
  logic [31:0] m_hi = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] resolve(input logic [31:0] lo, input logic [2:0] snd);
    logic [7:0] d, r, me;
    d = m_hi[31:24];
    me = 8'b1 << snd;
    r = '0;
    case (lo[19:18])
      2'd1: r = me;
      2'd2: r = 8'hFF;
      2'd3: r = ~me;
      default:
        for (int i = 0; i < N; i++) begin
          if (!lo[11]) r[i] = (d == 8'hFF) || (d == m_phys[i]);
          else if (m_fmt[i] == 4'hF) r[i] = (d & m_log[i]) != 0;
          else if (m_fmt[i] == 4'h0) r[i] = (d[7:4] == m_log[i][7:4]) && ((d[3:0] & m_log[i][3:0]) != 0);
        end
    endcase
    return r;
  endfunction

  task automatic wr_hi(input logic [7:0] dest);
    @(negedge clk);
    cmd_wr_en = 1; cmd_wr_hi = 1; cmd_wr_data = {dest, 24'h5A5A5A};
    m_hi = cmd_wr_data;
    @(negedge clk);
    cmd_wr_en = 0;
  endtask

  task automatic tbl(input int idx, input logic [7:0] p, input logic [7:0] l, input logic [3:0] f);
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_idx = 3'(idx); tbl_phys_id = p; tbl_log_id = l; tbl_fmt = f;
    m_phys[idx] = p; m_log[idx] = l; m_fmt[idx] = f;
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  // Drives one low-word write at the current negedge and pushes the expectation.
  task automatic lo_now(input logic [31:0] lo, input logic [2:0] snd, input string tag);
    exp_t e;
    logic [7:0] m, fx, nm, sm, in, st, rs;
    cmd_wr_en = 1; cmd_wr_hi = 0; cmd_wr_data = lo; sender_idx = snd;
    m = resolve(lo, snd);
    fx = 0; nm = 0; sm = 0; in = 0; st = 0; rs = 0;
    case (lo[10:8])
      3'd0: fx = m;
      3'd1: for (int i = N-1; i >= 0; i--) if (m[i]) fx = 8'b1 << i;
      3'd2: sm = m;
      3'd4: nm = m;
      3'd5: if (!lo[14] && lo[15]) rs = m; else in = m;
      3'd6: st = m;
      default: ;
    endcase
    for (int i = 0; i < N; i++) if (rs[i]) m_arb[i] = m_phys[i];
    e.mask = m; e.stb = {fx, nm, sm, in, st, rs}; e.vec = lo[7:0]; e.trig = lo[15];
    for (int i = 0; i < N; i++) e.arb[i*8 +: 8] = m_arb[i];
    e.due = cyc + 2; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send(input logic [31:0] lo, input logic [2:0] snd, input string tag);
    @(negedge clk);
    lo_now(lo, snd, tag);
    @(negedge clk);
    cmd_wr_en = 0;
  endtask

  function automatic logic [31:0] mk(input logic [1:0] sh, input bit trg, input bit lvl,
                                     input bit lg, input logic [2:0] md, input logic [7:0] v);
    return {12'h0, sh, 2'b00, trg, lvl, 2'b00, lg, md, v};
  endfunction

  // Scoreboard monitor
  initial begin
    wait (!rst);
    forever begin
      @(negedge clk);
      if (q.size() != 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(tgt_mask == e.mask, {e.tag, " mask"}, 64'(tgt_mask), 64'(e.mask));
        chk({fixed_stb, nmi_stb, smi_stb, init_stb, start_stb, resync_stb} == e.stb,
            {e.tag, " strobes"}, 64'({fixed_stb, nmi_stb, smi_stb, init_stb, start_stb, resync_stb}), 64'(e.stb));
        chk({vec_out, trig_out} == {e.vec, e.trig}, {e.tag, " vec/trig"},
            64'({vec_out, trig_out}), 64'({e.vec, e.trig}));
        chk(arb_id_flat == e.arb, {e.tag, " arb ids"}, arb_id_flat, e.arb);
      end else begin
        logic [47:0] s;
        s = {fixed_stb, nmi_stb, smi_stb, init_stb, start_stb, resync_stb};
        chk(s == 0, "R2/R1 strobes idle", 64'(s), 64'd0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_phys[i] = 8'(i); m_log[i] = 8'h00; m_fmt[i] = 4'hF; m_arb[i] = 8'h00;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 reset state
    chk({tgt_mask, fixed_stb, nmi_stb, smi_stb, init_stb, start_stb, resync_stb} == 0,
        "R13 reset outputs", 64'({tgt_mask, fixed_stb, nmi_stb, smi_stb, init_stb, start_stb, resync_stb}), 0);
    chk({vec_out, trig_out} == 0 && arb_id_flat == 0, "R13 reset vec/arb", arb_id_flat, 0);

    // R4 + R13: reset physical IDs equal the index
    wr_hi(8'h03);
    send(mk(2'd0, 0, 1, 0, 3'd0, 8'h41), 3'd0, "R4 R13 R7 phys reset id 3");
    // R1: high write alone, only idle checks follow
    wr_hi(8'hFF);
    repeat (3) @(negedge clk);
    send(mk(2'd0, 0, 1, 0, 3'd4, 8'h02), 3'd0, "R4 R9 phys broadcast NMI");
    wr_hi(8'h77);
    send(mk(2'd0, 1, 1, 0, 3'd0, 8'h33), 3'd0, "R4 phys no match");

    // R13 table writes
    for (int i = 0; i < N; i++) tbl(i, 8'h20 + 8'(i), 8'b1 << i, 4'hF);
    wr_hi(8'h25);
    send(mk(2'd0, 0, 1, 0, 3'd2, 8'h10), 3'd0, "R4 R9 R13 phys SMI new id");
    wr_hi(8'h5A);
    send(mk(2'd0, 1, 0, 1, 3'd0, 8'h61), 3'd0, "R5 R7 flat fixed");
    wr_hi(8'h58);
    send(mk(2'd0, 0, 1, 1, 3'd1, 8'h62), 3'd0, "R8 lowest of flat set");
    wr_hi(8'h00);
    send(mk(2'd0, 0, 1, 1, 3'd1, 8'h63), 3'd0, "R8 lowest empty set");

    send(mk(2'd1, 0, 1, 0, 3'd5, 8'h00), 3'd2, "R3 R9 self INIT");
    send(mk(2'd2, 0, 1, 0, 3'd6, 8'h9C), 3'd1, "R3 R11 all startup");
    send(mk(2'd3, 0, 1, 0, 3'd2, 8'h00), 3'd5, "R3 R9 others SMI");
    send(mk(2'd3, 1, 0, 0, 3'd5, 8'h00), 3'd7, "R10 INIT deassert resync");
    send(mk(2'd2, 0, 1, 0, 3'd3, 8'h11), 3'd0, "R12 reserved 3");
    send(mk(2'd2, 1, 1, 0, 3'd7, 8'h12), 3'd0, "R12 reserved 7");

    // R6 cluster addressing
    tbl(0, 8'h30, 8'h31, 4'h0);
    tbl(1, 8'h31, 8'h32, 4'h0);
    tbl(2, 8'h32, 8'h34, 4'h0);
    tbl(3, 8'h33, 8'h21, 4'h0);
    for (int i = 4; i < N; i++) tbl(i, 8'h40 + 8'(i), 8'hFF, 4'h5);
    wr_hi(8'h33);
    send(mk(2'd0, 0, 1, 1, 3'd0, 8'h70), 3'd0, "R6 cluster 3 members 0,1");
    wr_hi(8'h2E);
    send(mk(2'd0, 0, 1, 1, 3'd0, 8'h71), 3'd0, "R6 cluster nibble match no member");
    wr_hi(8'h2F);
    send(mk(2'd0, 0, 1, 1, 3'd4, 8'h72), 3'd0, "R6 R9 cluster 2 NMI");

    // R2 back-to-back sends
    wr_hi(8'hFF);
    @(negedge clk);
    lo_now(mk(2'd0, 0, 1, 0, 3'd0, 8'hA1), 3'd0, "R2 back-to-back first");
    @(negedge clk);
    lo_now(mk(2'd1, 0, 1, 0, 3'd4, 8'hA2), 3'd6, "R2 back-to-back second");
    @(negedge clk);
    cmd_wr_en = 0;
    repeat (6) @(negedge clk);

    chk(q.size() == 0, "R2 all sends observed", 64'(q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule